// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave

This block receives configuration for a stereo headphone output stage over a two-wire serial bus. It runs on a fast system clock that oversamples the bus clock and data lines. It detects bus start and stop conditions, matches a fixed 7-bit device address with the write direction, and acknowledges that byte and every data byte that follows. The top bit of each data byte chooses one of two internal 7-bit registers. The lower seven bits are written into that register. One register holds the mode bits and the other holds the volume setting.

The two registers are decoded into control levels: per-channel amplifier enables, mutes, a mono-sum route, a bias enable, a charge-pump enable and a 6-bit volume code. The decode follows a fixed precedence. Global shutdown wins first, then pump-only operation, then the per-channel shutdown bits. The block never answers a read. The data line is driven only as an open-drain pull-down enable.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: After reset the mode register is all zeros and the volume register holds global shutdown = 1 with volume code 0. As a result every enable output is 0, mono_sum is 0, both mutes are 0 and vol_code is 0.
- R2: An address byte whose upper seven bits equal 1100000 and whose last bit (R/W) is 0 is acknowledged: sda_oe is 1 during the ninth SCL high phase. Any other address is not acknowledged, and no register changes for the rest of that transfer.
- R3: An address of 1100000 with R/W = 1 is not acknowledged. Bytes clocked afterwards in that transfer get no acknowledge and change no register.
- R4: Data bit 7 selects the register. When bit 7 = 0 the mode register is written, with bit 6 = left shutdown, bit 5 = bias shutdown, bit 4 = pump-only, bit 3 = reserved, bit 2 = left mute, bit 1 = right shutdown and bit 0 = right mute. When bit 7 = 1 the volume register is written, with bit 6 = global shutdown and bits 5..0 = the volume code, which appears on vol_code.
- R5: Global shutdown = 1 forces pump_en, both amplifier enables, bias_en and mono_sum to 0, whatever the mode bits hold.
- R6: With global shutdown = 0 and pump-only = 1, pump_en = 1 and both amplifier enables, bias_en and mono_sum are 0, whatever the channel shutdown bits hold.
- R7: With global shutdown = 0 and pump-only = 0, each amplifier enable is the inverse of its channel's shutdown bit. mono_sum = 1 exactly when right shutdown = 1 and left shutdown = 0. bias_en is the inverse of bias shutdown, and pump_en = 1.
- R8: mute_l and mute_r follow mode bits 2 and 0 directly, whatever the shutdown state.
- R9: Every data byte in an addressed write transfer is acknowledged and written, including the second and later bytes.
- R10: A STOP or a repeated START in the middle of a byte leaves both registers unchanged. A repeated START begins a new address phase.
- R11: sda_oe rises only while the synchronised SCL is low. A register output changes only in the cycle after a falling SCL edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| pump_en | output | 1 | Charge pump enable |
| amp_l_en | output | 1 | Left amplifier enable |
| amp_r_en | output | 1 | Right amplifier enable |
| mono_sum | output | 1 | Route both inputs to the left output |
| bias_en | output | 1 | Bias reference enable |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |
| vol_code | output | 6 | Volume code, 0 = most attenuation |

## Verification
A receiver state that is wrong shows up on the bus first. A bad bit count or address compare moves or removes the acknowledge pulse, and this is visible at the ninth clock of the byte that failed. A write that lands in the wrong register, takes a wrong field, or happens after an aborted byte appears on the decoded outputs within a few system clocks of the eighth falling SCL edge. The bench compares those outputs after every transfer. Errors in the precedence logic show only for particular combinations of mode and volume bits, so random register contents are mixed with directed cases that pit each shutdown level against the others.

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1100000,
  parameter int         VOL_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             pump_en,
  output logic             amp_l_en,
  output logic             amp_r_en,
  output logic             mono_sum,
  output logic             bias_en,
  output logic             mute_l,
  output logic             mute_r,
  output logic [VOL_W-1:0] vol_code
);
  localparam int BYTE_W = VOL_W + 2;
  localparam int REG_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKA, S_DATA, S_ACKD, S_SKIP} st_t;

  logic [1:0]        scl_sync, sda_sync;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [REG_W-1:0]  mode_r, vol_r;
  st_t               st;

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_hit  = (sh[BYTE_W-1:1] == DEV_ADDR) && !sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      sh       <= '0;
      cnt      <= '0;
      st       <= S_IDLE;
      mode_r   <= '0;
      vol_r    <= REG_W'(1) << (REG_W - 1);
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      if (start_c) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_DATA: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (st == S_ADDR) begin
                st <= addr_hit ? S_ACKA : S_SKIP;
              end else begin
                st <= S_ACKD;
                if (sh[BYTE_W-1]) vol_r  <= sh[REG_W-1:0];
                else              mode_r <= sh[REG_W-1:0];
              end
            end
          end
          S_ACKA, S_ACKD: begin
            if (scl_fall) begin
              st  <= S_DATA;
              cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (st == S_ACKA) || (st == S_ACKD);

  wire g_off   = vol_r[REG_W-1];
  wire cp_only = mode_r[4];
  wire sd_l    = mode_r[6];
  wire sd_r    = mode_r[1];
  wire amps_ok = !g_off && !cp_only;

  assign pump_en  = !g_off;
  assign amp_l_en = amps_ok && !sd_l;
  assign amp_r_en = amps_ok && !sd_r;
  assign mono_sum = amps_ok && sd_r && !sd_l;
  assign bias_en  = amps_ok && !mode_r[5];
  assign mute_l   = mode_r[2];
  assign mute_r   = mode_r[0];
  assign vol_code = vol_r[VOL_W-1:0];

  // R5
  gshdn_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> !(amp_l_en || amp_r_en || bias_en || mono_sum));

  // R7
  mono_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mono_sum |-> (amp_l_en && !amp_r_en));

  // R11
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11
  vol_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_code) |-> $past(scl_fall));

  // R11
  mute_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mute_l, mute_r}) |-> $past(scl_fall));
endmodule

// File: tb/tb_i2c_ctrl_slave.sv
module tb_i2c_ctrl_slave;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'b1100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, pump_en, amp_l_en, amp_r_en, mono_sum, bias_en, mute_l, mute_r;
  logic [5:0] vol_code;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [6:0] mode_m = 7'h00;
  logic [6:0] vol_m  = 7'h40;

  always #5 clk = ~clk;

  i2c_ctrl_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pump_en(pump_en), .amp_l_en(amp_l_en), .amp_r_en(amp_r_en),
    .mono_sum(mono_sum), .bias_en(bias_en), .mute_l(mute_l), .mute_r(mute_r),
    .vol_code(vol_code)
  );

  function automatic logic [6:0] expect_ctl(input logic [6:0] m, input logic [6:0] v);
    logic g, cp, ok;
    g  = v[6];
    cp = m[4];
    ok = !g && !cp;
    return {!g, ok && !m[6], ok && !m[1], ok && m[1] && !m[6], ok && !m[5], m[2], m[0]};
  endfunction

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic check_outputs(input string req);
    logic [6:0] got, exp;
    got = {pump_en, amp_l_en, amp_r_en, mono_sum, bias_en, mute_l, mute_r};
    exp = expect_ctl(mode_m, vol_m);
    checks++;
    if (got !== exp || vol_code !== vol_m[5:0]) begin
      fails++;
      $display("FAIL %s: ctl=%b vol=%0d expected ctl=%b vol=%0d", req, got, vol_code, exp, vol_m[5:0]);
    end
  endtask

  task automatic check_ack(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: ack=%b expected %b", req, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic model_write(input logic [7:0] d);
    if (d[7]) vol_m = d[6:0];
    else      mode_m = d[6:0];
  endtask

  task automatic write_reg(input logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    check_ack({req, " addr ack"}, a, 1'b1);
    send_byte(d, a);
    check_ack({req, " data ack"}, a, 1'b1);
    model_write(d);
    bus_stop();
    check_outputs(req);
  endtask

  initial begin
    logic a;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    wq(2);
    check_outputs("R1 reset");

    write_reg(8'b1000_0000 | 8'd0, "R5 wake vol0");
    write_reg(8'b0001_0110, "R6 pump-only over shutdown");
    write_reg(8'b0000_0010, "R7 mono route");
    write_reg(8'b0100_0000, "R7 left off");
    write_reg(8'b0100_0010, "R7 both off");
    write_reg(8'b0010_0101, "R8 mutes bias off");
    write_reg(8'b1011_1111, "R4 volume max");
    write_reg(8'b1110_1010, "R5 global shutdown");
    write_reg(8'b0000_0000, "R5 mode clear under shutdown");
    write_reg(8'b1001_0101, "R4 volume mid");

    bus_start();
    send_byte({7'b1100001, 1'b0}, a);
    check_ack("R2 wrong address", a, 1'b0);
    send_byte(8'b1000_0011, a);
    check_ack("R2 no data ack", a, 1'b0);
    bus_stop();
    check_outputs("R2 unchanged");

    bus_start();
    send_byte({ADDR, 1'b1}, a);
    check_ack("R3 read address", a, 1'b0);
    send_byte(8'b0111_1111, a);
    check_ack("R3 silent", a, 1'b0);
    bus_stop();
    check_outputs("R3 unchanged");

    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'b0000_0101, a);
    check_ack("R9 first byte", a, 1'b1);
    model_write(8'b0000_0101);
    send_byte(8'b1010_1010, a);
    check_ack("R9 second byte", a, 1'b1);
    model_write(8'b1010_1010);
    bus_stop();
    check_outputs("R9 multi byte");

    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_bits(8'b1111_1111, 5);
    bus_stop();
    check_outputs("R10 stop mid byte");

    bus_start();
    send_byte({ADDR, 1'b0}, a);
    send_bits(8'b0111_1111, 6);
    bus_start();
    send_byte({ADDR, 1'b0}, a);
    check_ack("R10 restart addr ack", a, 1'b1);
    send_byte(8'b1000_1100, a);
    model_write(8'b1000_1100);
    bus_stop();
    check_outputs("R10 repeated start");

    for (int t = 0; t < 40; t++) begin
      logic [7:0] ab;
      logic hit;
      int nb;
      if ($urandom_range(0, 9) < 7) ab = {ADDR, 1'b0};
      else ab = 8'($urandom);
      hit = (ab == {ADDR, 1'b0});
      nb = $urandom_range(1, 3);
      bus_start();
      send_byte(ab, a);
      check_ack("R2 random addr", a, hit);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        send_byte(d, a);
        check_ack("R9 random data", a, hit);
        if (hit) model_write(d);
      end
      bus_stop();
      check_outputs("R4 random write");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule